// File: doc/BRIEF.md
# Channel Command Register Executor

This block is the per-channel command register of a multi-channel serial controller. The host writes a command byte into it. On the next clock the block decodes that byte and applies its effects to the channel state. The register then clears itself to zero, and that zero tells the host the command has finished. The byte has two formats, and its top bit selects which one applies.

With the top bit clear, the byte is a channel-control command. It can do any of the following:

- reset the whole device back to power-on values;
- reinitialize the protocol-specific registers;
- clear the channel;
- enable or disable the transmitter and the receiver.

With the top bit set, the byte is a clearing command. It can clear either general timer or both timers, and it can clear the receive path and the transmit path.

The block drives the following outputs:

- the transmit-enable and receive-enable status bits;
- the flow-control option bits, which the host loads through a side port;
- one-cycle strobes toward the timers, the datapaths, the protocol registers and the global reset;
- a revision register;
- two sticky error flags.

Top module: `chan_cmd_exec`

## Requirements
- R1: After reset, `cmd_rdata`, the enable bits, the flow options, every strobe, `rev_code`, `proto_err` and `overrun` are all zero.
- R2: A write while `cmd_rdata` is zero loads the byte. `cmd_rdata` shows the byte for exactly one cycle and is zero in the following cycle. All effects of the command appear in that following cycle, and every strobe is high for that one cycle only.
- R3: A write while `cmd_rdata` is nonzero is discarded and sets `overrun`. `overrun` stays set until a reset-all executes.
- R4: A control byte (bit 7 = 0) with bit 4 set is reset-all. Its other bits have no effect. It returns the enable bits, flow options, `proto_err`, `overrun` and the clear history to zero, pulses `glob_rst`, and loads `rev_code` with the parameter `REV`.
- R5: In a control byte, bit 3 sets `tx_en` and bit 2 clears it, and bit 1 sets `rx_en` and bit 0 clears it. When both the set and the clear bit of one direction are present, the clear wins.
- R6: While `async_mode` is 1, any transmit enable or disable command zeroes `tx_flow`, and any receive enable or disable command zeroes `rx_flow`. While `async_mode` is 0, both sets of flow bits are left as they are.
- R7: Control bit 5 (initialize) pulses `proto_init` when the channel is idle. The channel is idle when neither `tx_en` nor `rx_en` is set.
- R8: An initialize on a running channel is legal only if a clear-channel command (control bit 6) has executed since the last initialize, or if bit 6 is in the same byte. Otherwise `proto_init` stays low and the sticky `proto_err` is set.
- R9: Control bit 6 (clear channel) pulses both `rx_clr` and `tx_clr`.
- R10: A clearing byte (bit 7 = 1) with bits 2:0 zero maps its bits to strobes: bit 6 to `tmr1_clr`, bit 5 to `tmr2_clr`, bit 4 to `rx_clr` and bit 3 to `tx_clr`. Any combination of these may pulse together.
- R11: A clearing byte with any of bits 2:0 set has no effect on strobes or channel state, and it sets `proto_err`.
- R12: `opt_wr` loads `tx_flow` and `rx_flow` from `opt_tx_in` and `opt_rx_in`. If a command that zeroes a flow field executes in the same cycle, the zero wins for that field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe for the command byte |
| host_wdata | input | 8 | Command byte |
| cmd_rdata | output | 8 | Command register contents (nonzero while pending) |
| async_mode | input | 1 | Channel runs the asynchronous protocol |
| opt_wr | input | 1 | Load the flow-control options |
| opt_tx_in | input | FW | New transmit flow options |
| opt_rx_in | input | FW | New receive flow options |
| tx_en | output | 1 | Transmitter enabled |
| rx_en | output | 1 | Receiver enabled |
| tx_flow | output | FW | Transmit flow-control options |
| rx_flow | output | FW | Receive flow-control options |
| tmr1_clr | output | 1 | Clear strobe for general timer 1 |
| tmr2_clr | output | 1 | Clear strobe for general timer 2 |
| rx_clr | output | 1 | Receive path clear strobe |
| tx_clr | output | 1 | Transmit path clear strobe |
| proto_init | output | 1 | Protocol register initialize strobe |
| glob_rst | output | 1 | Global reset strobe |
| rev_code | output | 8 | Revision code, loaded by reset-all |
| proto_err | output | 1 | Sticky illegal-command flag |
| overrun | output | 1 | Sticky write-while-busy flag |

## Verification
Each internal error shows at the ports within one cycle of the command that exposes it:

- If the holding register fails to clear, `cmd_rdata` stays nonzero a second cycle, and the next write wrongly raises `overrun`.
- If the clear history is wrong, the next initialize on a running channel gives the wrong result. Either `proto_init` pulses when it should not, or `proto_err` rises when it should not.
- A mistake in the flow-clearing rule shows on `tx_flow` or `rx_flow` in the cycle after the command executes.

The general timers are outside this block. When a timer holds 01h and expires in the same cycle as its clear, either ordering is acceptable, so the checks look only at the clear strobes.

// File: rtl/chan_cmd_pkg.sv
package chan_cmd_pkg;
  localparam int CMD_W = 8;

  typedef struct packed {
    logic rst_all;
    logic init;
    logic clr_chan;
    logic tx_on;
    logic tx_off;
    logic rx_on;
    logic rx_off;
    logic t1;
    logic t2;
    logic crx;
    logic ctx;
    logic bad;
  } cmd_dec_t;
endpackage

// File: rtl/chan_cmd_hold.sv
module chan_cmd_hold
  import chan_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CMD_W-1:0] wdata,
  input  logic             ovr_clr,
  output logic [CMD_W-1:0] q,
  output logic             busy,
  output logic             ovr
);
  logic [CMD_W-1:0] q_n;
  logic             ovr_n;

  assign busy = (q != '0);

  always_comb begin
    q_n   = q;
    ovr_n = ovr;
    if (busy) q_n = '0;
    if (ovr_clr) ovr_n = 1'b0;
    if (wr) begin
      if (busy) ovr_n = 1'b1;
      else      q_n   = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q   <= '0;
      ovr <= 1'b0;
    end else begin
      q   <= q_n;
      ovr <= ovr_n;
    end
  end
endmodule

// File: rtl/chan_cmd_decode.sv
module chan_cmd_decode
  import chan_cmd_pkg::*;
(
  input  logic             vld,
  input  logic [CMD_W-1:0] b,
  output cmd_dec_t         d
);
  always_comb begin
    d = '0;
    if (vld) begin
      if (b[7]) begin
        if (b[2:0] != 3'b000) begin
          d.bad = 1'b1;
        end else begin
          d.t1  = b[6];
          d.t2  = b[5];
          d.crx = b[4];
          d.ctx = b[3];
        end
      end else if (b[4]) begin
        d.rst_all = 1'b1;
      end else begin
        d.clr_chan = b[6];
        d.init     = b[5];
        d.tx_on    = b[3];
        d.tx_off   = b[2];
        d.rx_on    = b[1];
        d.rx_off   = b[0];
      end
    end
  end
endmodule

// File: rtl/chan_cmd_state.sv
module chan_cmd_state
  import chan_cmd_pkg::*;
#(
  parameter int              FW  = 2,
  parameter logic [CMD_W-1:0] REV = 8'h3C
)(
  input  logic             clk,
  input  logic             rst_n,
  input  cmd_dec_t         d,
  input  logic             async_mode,
  input  logic             opt_wr,
  input  logic [FW-1:0]    opt_tx_in,
  input  logic [FW-1:0]    opt_rx_in,
  output logic             tx_en,
  output logic             rx_en,
  output logic [FW-1:0]    tx_flow,
  output logic [FW-1:0]    rx_flow,
  output logic             tmr1_clr,
  output logic             tmr2_clr,
  output logic             rx_clr,
  output logic             tx_clr,
  output logic             proto_init,
  output logic             glob_rst,
  output logic [CMD_W-1:0] rev_code,
  output logic             proto_err
);
  logic             cseen, cseen_n;
  logic             tx_en_n, rx_en_n, err_n;
  logic [FW-1:0]    tx_flow_n, rx_flow_n;
  logic             t1_n, t2_n, rxc_n, txc_n, init_n, grst_n;
  logic [CMD_W-1:0] rev_n;
  logic             running, init_ok;

  assign running = tx_en | rx_en;
  assign init_ok = !running || cseen || d.clr_chan;

  always_comb begin
    tx_en_n   = tx_en;
    rx_en_n   = rx_en;
    tx_flow_n = tx_flow;
    rx_flow_n = rx_flow;
    err_n     = proto_err;
    cseen_n   = cseen;
    rev_n     = rev_code;
    t1_n      = 1'b0;
    t2_n      = 1'b0;
    rxc_n     = 1'b0;
    txc_n     = 1'b0;
    init_n    = 1'b0;
    grst_n    = 1'b0;
    if (d.rst_all) begin
      tx_en_n   = 1'b0;
      rx_en_n   = 1'b0;
      tx_flow_n = '0;
      rx_flow_n = '0;
      err_n     = 1'b0;
      cseen_n   = 1'b0;
      grst_n    = 1'b1;
      rev_n     = REV;
    end else begin
      if (opt_wr) begin
        tx_flow_n = opt_tx_in;
        rx_flow_n = opt_rx_in;
      end
      if (d.tx_on)  tx_en_n = 1'b1;
      if (d.tx_off) tx_en_n = 1'b0;
      if (d.rx_on)  rx_en_n = 1'b1;
      if (d.rx_off) rx_en_n = 1'b0;
      if (async_mode && (d.tx_on || d.tx_off)) tx_flow_n = '0;
      if (async_mode && (d.rx_on || d.rx_off)) rx_flow_n = '0;
      if (d.clr_chan) cseen_n = 1'b1;
      if (d.init) begin
        if (init_ok) begin
          init_n  = 1'b1;
          cseen_n = 1'b0;
        end else begin
          err_n = 1'b1;
        end
      end
      if (d.bad) err_n = 1'b1;
      t1_n  = d.t1;
      t2_n  = d.t2;
      rxc_n = d.crx | d.clr_chan;
      txc_n = d.ctx | d.clr_chan;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en      <= 1'b0;
      rx_en      <= 1'b0;
      tx_flow    <= '0;
      rx_flow    <= '0;
      proto_err  <= 1'b0;
      cseen      <= 1'b0;
      rev_code   <= '0;
      tmr1_clr   <= 1'b0;
      tmr2_clr   <= 1'b0;
      rx_clr     <= 1'b0;
      tx_clr     <= 1'b0;
      proto_init <= 1'b0;
      glob_rst   <= 1'b0;
    end else begin
      tx_en      <= tx_en_n;
      rx_en      <= rx_en_n;
      tx_flow    <= tx_flow_n;
      rx_flow    <= rx_flow_n;
      proto_err  <= err_n;
      cseen      <= cseen_n;
      rev_code   <= rev_n;
      tmr1_clr   <= t1_n;
      tmr2_clr   <= t2_n;
      rx_clr     <= rxc_n;
      tx_clr     <= txc_n;
      proto_init <= init_n;
      glob_rst   <= grst_n;
    end
  end
endmodule

// File: rtl/chan_cmd_exec.sv
module chan_cmd_exec
  import chan_cmd_pkg::*;
#(
  parameter int              FW  = 2,
  parameter logic [CMD_W-1:0] REV = 8'h3C
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_wr,
  input  logic [CMD_W-1:0] host_wdata,
  output logic [CMD_W-1:0] cmd_rdata,
  input  logic             async_mode,
  input  logic             opt_wr,
  input  logic [FW-1:0]    opt_tx_in,
  input  logic [FW-1:0]    opt_rx_in,
  output logic             tx_en,
  output logic             rx_en,
  output logic [FW-1:0]    tx_flow,
  output logic [FW-1:0]    rx_flow,
  output logic             tmr1_clr,
  output logic             tmr2_clr,
  output logic             rx_clr,
  output logic             tx_clr,
  output logic             proto_init,
  output logic             glob_rst,
  output logic [CMD_W-1:0] rev_code,
  output logic             proto_err,
  output logic             overrun
);
  logic     busy;
  cmd_dec_t dec;

  chan_cmd_hold u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (host_wr),
    .wdata   (host_wdata),
    .ovr_clr (dec.rst_all),
    .q       (cmd_rdata),
    .busy    (busy),
    .ovr     (overrun)
  );

  chan_cmd_decode u_dec (
    .vld (busy),
    .b   (cmd_rdata),
    .d   (dec)
  );

  chan_cmd_state #(.FW(FW), .REV(REV)) u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .d          (dec),
    .async_mode (async_mode),
    .opt_wr     (opt_wr),
    .opt_tx_in  (opt_tx_in),
    .opt_rx_in  (opt_rx_in),
    .tx_en      (tx_en),
    .rx_en      (rx_en),
    .tx_flow    (tx_flow),
    .rx_flow    (rx_flow),
    .tmr1_clr   (tmr1_clr),
    .tmr2_clr   (tmr2_clr),
    .rx_clr     (rx_clr),
    .tx_clr     (tx_clr),
    .proto_init (proto_init),
    .glob_rst   (glob_rst),
    .rev_code   (rev_code),
    .proto_err  (proto_err)
  );
endmodule

// File: rtl/chan_cmd_exec_chk.sv
module chan_cmd_exec_chk #(
  parameter logic [7:0] REV = 8'h3C
)(
  input logic       clk,
  input logic       rst_n,
  input logic       host_wr,
  input logic [7:0] cmd_rdata,
  input logic       tx_en,
  input logic       rx_en,
  input logic       tmr1_clr,
  input logic       tmr2_clr,
  input logic       proto_init,
  input logic       glob_rst,
  input logic [7:0] rev_code,
  input logic       proto_err,
  input logic       overrun
);
  logic rst_cmd;
  assign rst_cmd = (cmd_rdata != 8'h00) && !cmd_rdata[7] && cmd_rdata[4];

  p_selfclear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_rdata != 8'h00) |=> (cmd_rdata == 8'h00));

  p_overrun_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && cmd_rdata != 8'h00) |=> overrun);

  p_overrun_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !rst_cmd) |=> overrun);

  p_glob_rst_r4: assert property (@(posedge clk) disable iff (!rst_n)
    glob_rst |-> (!tx_en && !rx_en && !proto_err && rev_code == REV));

  p_init_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    proto_init |=> !proto_init);

  p_bad_mode2_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_rdata[7] && cmd_rdata[2:0] != 3'b000)
      |=> (proto_err && !tmr1_clr && !tmr2_clr));
endmodule

bind chan_cmd_exec chan_cmd_exec_chk #(.REV(REV)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_wr    (host_wr),
  .cmd_rdata  (cmd_rdata),
  .tx_en      (tx_en),
  .rx_en      (rx_en),
  .tmr1_clr   (tmr1_clr),
  .tmr2_clr   (tmr2_clr),
  .proto_init (proto_init),
  .glob_rst   (glob_rst),
  .rev_code   (rev_code),
  .proto_err  (proto_err),
  .overrun    (overrun)
);

// File: tb/chan_cmd_exec_bench.sv
module chan_cmd_exec_bench;
  localparam int         FW  = 2;
  localparam logic [7:0] REV = 8'h3C;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          host_wr = 1'b0;
  logic [7:0]    host_wdata = 8'h00;
  logic [7:0]    cmd_rdata;
  logic          async_mode = 1'b0;
  logic          opt_wr = 1'b0;
  logic [FW-1:0] opt_tx_in = '0;
  logic [FW-1:0] opt_rx_in = '0;
  logic          tx_en, rx_en, tmr1_clr, tmr2_clr, rx_clr, tx_clr;
  logic          proto_init, glob_rst, proto_err, overrun;
  logic [FW-1:0] tx_flow, rx_flow;
  logic [7:0]    rev_code;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  int cycles = 0;

  always #5 clk = ~clk;

  chan_cmd_exec #(.FW(FW), .REV(REV)) u_chan_cmd_exec (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
    .cmd_rdata(cmd_rdata), .async_mode(async_mode), .opt_wr(opt_wr),
    .opt_tx_in(opt_tx_in), .opt_rx_in(opt_rx_in), .tx_en(tx_en), .rx_en(rx_en),
    .tx_flow(tx_flow), .rx_flow(rx_flow), .tmr1_clr(tmr1_clr), .tmr2_clr(tmr2_clr),
    .rx_clr(rx_clr), .tx_clr(tx_clr), .proto_init(proto_init), .glob_rst(glob_rst),
    .rev_code(rev_code), .proto_err(proto_err), .overrun(overrun)
  );

  // behavioural reference model
  int m_cmd, m_ovr, m_tx, m_rx, m_txf, m_rxf, m_err, m_seen, m_rev;
  int m_t1, m_t2, m_crx, m_ctx, m_init, m_grst;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cmd = 0; m_ovr = 0; m_tx = 0; m_rx = 0; m_txf = 0; m_rxf = 0;
      m_err = 0; m_seen = 0; m_rev = 0;
      m_t1 = 0; m_t2 = 0; m_crx = 0; m_ctx = 0; m_init = 0; m_grst = 0;
    end else begin
      int c;
      int nxt;
      c = m_cmd;
      m_t1 = 0; m_t2 = 0; m_crx = 0; m_ctx = 0; m_init = 0; m_grst = 0;
      nxt = 0;
      if (host_wr) begin
        if (c != 0) m_ovr = 1;
        else nxt = host_wdata;
      end
      if (c != 0 && c < 128 && (c / 16) % 2 == 1) begin
        // reset-all (R4)
        m_tx = 0; m_rx = 0; m_txf = 0; m_rxf = 0; m_err = 0; m_seen = 0;
        m_ovr = host_wr ? 1 : 0;
        m_grst = 1; m_rev = REV;
      end else begin
        if (opt_wr) begin m_txf = opt_tx_in; m_rxf = opt_rx_in; end
        if (c >= 128) begin
          if (c % 8 != 0) m_err = 1;
          else begin
            m_t1  = (c / 64) % 2; m_t2  = (c / 32) % 2;
            m_crx = (c / 16) % 2; m_ctx = (c / 8) % 2;
          end
        end else if (c != 0) begin
          int was_run;
          was_run = (m_tx != 0 || m_rx != 0) ? 1 : 0;
          if ((c / 8) % 2 == 1) m_tx = 1;
          if ((c / 4) % 2 == 1) m_tx = 0;
          if ((c / 2) % 2 == 1) m_rx = 1;
          if (c % 2 == 1)       m_rx = 0;
          if (async_mode && (c / 4) % 4 != 0) m_txf = 0;
          if (async_mode && c % 4 != 0)       m_rxf = 0;
          if ((c / 64) % 2 == 1) begin m_seen = 1; m_crx = 1; m_ctx = 1; end
          if ((c / 32) % 2 == 1) begin
            if (!was_run || m_seen == 1) begin m_init = 1; m_seen = 0; end
            else m_err = 1;
          end
        end
      end
      m_cmd = nxt;
    end
  end

  task automatic chk(input string req, input string nm, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, nm, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2", "cmd_rdata", cmd_rdata, m_cmd);
      chk("R3", "overrun", overrun, m_ovr);
      chk("R4", "glob_rst", glob_rst, m_grst);
      chk("R4", "rev_code", rev_code, m_rev);
      chk("R5", "tx_en", tx_en, m_tx);
      chk("R5", "rx_en", rx_en, m_rx);
      chk("R6", "tx_flow", tx_flow, m_txf);
      chk("R6", "rx_flow", rx_flow, m_rxf);
      chk("R7", "proto_init", proto_init, m_init);
      chk("R8", "proto_err", proto_err, m_err);
      chk("R9", "rx_clr", rx_clr, m_crx);
      chk("R9", "tx_clr", tx_clr, m_ctx);
      chk("R10", "tmr1_clr", tmr1_clr, m_t1);
      chk("R10", "tmr2_clr", tmr2_clr, m_t2);
    end
  end

  task automatic wr(input logic [7:0] b);
    @(negedge clk); host_wr = 1'b1; host_wdata = b;
    @(negedge clk); host_wr = 1'b0; host_wdata = 8'h00;
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1", "outputs after reset",
        {cmd_rdata, rev_code, tx_en, rx_en, tx_flow, rx_flow, proto_err, overrun}, 0);
    // R12: load flow options
    @(negedge clk); opt_wr = 1'b1; opt_tx_in = 2'b11; opt_rx_in = 2'b10;
    @(negedge clk); opt_wr = 1'b0;
    // R5 enable both, sync mode keeps flow (R6)
    wr(8'h0A);
    // R2 readback timing: written byte visible one cycle
    @(negedge clk); host_wr = 1'b1; host_wdata = 8'h80;
    @(negedge clk); host_wr = 1'b0;
    chk("R2", "pending byte", cmd_rdata, 8'h80);
    @(negedge clk);
    chk("R2", "self clear", cmd_rdata, 0);
    // R3 overrun: back-to-back writes
    @(negedge clk); host_wr = 1'b1; host_wdata = 8'hC0;
    @(negedge clk); host_wdata = 8'h88;
    @(negedge clk); host_wr = 1'b0;
    repeat (2) @(negedge clk);
    chk("R3", "overrun sticky", overrun, 1);
    // R6 async: transmit disable clears tx flow only
    async_mode = 1'b1;
    wr(8'h04);
    // R8 init on running channel without clear
    wr(8'h20);
    // R9 then R7 clear then init
    wr(8'h40);
    wr(8'h20);
    // R8 init and clear in same byte while running
    wr(8'h62);
    // R10 timer and path clears
    wr(8'hE0);
    wr(8'h98);
    // R11 illegal clearing byte
    wr(8'h81);
    chk("R11", "no timer strobe", tmr1_clr, 0);
    // R5 set and clear together: clear wins
    wr(8'h0F);
    // R12 option load colliding with a flow-clearing command
    @(negedge clk); opt_wr = 1'b1; opt_tx_in = 2'b01; opt_rx_in = 2'b11;
    @(negedge clk); opt_wr = 1'b0;
    @(negedge clk); host_wr = 1'b1; host_wdata = 8'h08;
    @(negedge clk); host_wr = 1'b0; opt_wr = 1'b1; opt_tx_in = 2'b10; opt_rx_in = 2'b01;
    @(negedge clk); opt_wr = 1'b0;
    chk("R12", "tx_flow zeroed over load", tx_flow, 0);
    chk("R12", "rx_flow loaded", rx_flow, 2'b01);
    // R4 reset-all with other bits set
    wr(8'h7F);
    chk("R4", "rev after reset-all", rev_code, REV);
    chk("R4", "overrun cleared", overrun, 0);
    // R7 init on idle channel
    async_mode = 1'b0;
    wr(8'h20);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule